// File: doc/BRIEF.md
# Serial ADC Slave Emulator

This block stands in for the digital side of a 12-bit serial analog-to-digital converter. A host controller under test talks to it through an active-low chip select, a serial clock that idles high, a serial data input and a serial data output. The emulator is fully synchronous to a system clock. It samples the serial pins with that clock, detects their edges, and runs the converter's frame protocol. Each frame has sixteen serial clocks. The first eight data-in bits form a control word. A 12-bit value taken from a parallel input port is returned on data-out behind four zero bits, most significant bit first.

The two low bits of the committed control word select a power mode. The emulator tracks a powered-up flag that moves on the serial clock edges a real converter would use. In auto-shutdown mode it also times the wake-up period in system clocks. If the host samples before that period has run out, the emulator raises a violation flag. A host controller bench can read the committed control word, the power flag and the violation flag to judge whether the host drives the protocol correctly.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset the control word reads 0x00, the power flag is 1, data-out sits at its idle level (1 by default) and the violation flag is 0.
- R2: Rising serial clocks 1 to 8 of a frame shift data-in into a pending word, first bit into bit 7. The pending word becomes the visible control word on the 16th rising serial clock.
- R3: If chip select rises before the 16th rising serial clock, the control word is left unchanged. Rising serial clocks after the 16th are ignored.
- R4: While chip select is high, data-out holds the idle level. When chip select falls, data-out drives 0. After falling serial clock k (k = 1..16), data-out carries bit k-1, counted from the MSB, of the 16-bit word {4'b0000, sample}.
- R5: The sample value is captured from the parallel input on the 2nd rising serial clock. Later changes on that input do not alter the bits shifted out in the same frame.
- R6: Control word bits [1:0] select the mode: 00 normal, 01 full shutdown, 10 auto-shutdown, 11 behaves as normal. On the 16th rising serial clock the power flag becomes 1 for 00 or 11 and 0 otherwise. A change from full shutdown to normal therefore powers up only at that edge.
- R7: While the committed mode is full shutdown, the power flag stays 0 across whole and aborted frames. The control word keeps its value until a complete frame changes it.
- R8: With auto-shutdown committed and the power flag at 0, the first falling serial clock of a frame sets the power flag. It clears again on the 16th rising serial clock, or when chip select rises early. After a change from full shutdown to auto-shutdown, the power flag stays 0 until the next frame's first falling serial clock.
- R9: The violation flag is set on the 2nd rising serial clock if that edge comes no more than WAKE_CLKS system clocks after the wake-up edge of R8. It holds until the next chip-select fall and is never set in a frame without a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial data from the host |
| sampleIn | input | 12 | Value returned as the conversion result |
| dout | output | 1 | Serial data to the host |
| ctrlWord | output | 8 | Committed control word |
| powered | output | 1 | 1 while the emulated converter is powered up |
| wakeViol | output | 1 | Host sampled inside the wake-up window |

## Verification
A wrong edge counter shows up quickly. Data-out shows a shifted or duplicated bit on the very next falling serial clock, and the control word commits on the wrong rising edge or fails to survive an aborted frame. A wrong power state shows on the power flag on the first falling clock of the next frame, or at its 16th rising clock. The full-shutdown-to-normal and full-shutdown-to-auto transitions are checked at those exact edges. The wake window is probed at exactly WAKE_CLKS and at one more clock, so an off-by-one in the wake counter turns into a wrong violation flag during that same frame.

// File: rtl/adcslv_pkg.sv
package adcslv_pkg;
  localparam int CTRL_W    = 8;
  localparam int DATA_W    = 12;
  localparam int LEAD_W    = 4;
  localparam int FRAME_LEN = LEAD_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_FULLDOWN = 2'b01,
    PM_AUTODOWN = 2'b10,
    PM_SPARE    = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic             frameStart;
    logic             shiftEn;
    logic             capture;
    logic             commit;
    logic             outStep;
    logic [CNT_W-1:0] outIdx;
    logic             idle;
  } strobe_t;
endpackage

// File: rtl/adcslv_ctrl.sv
module adcslv_ctrl
  import adcslv_pkg::*;
#(
  parameter int WAKE_CLKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic [1:0] pendingPm,
  input  logic [1:0] curPm,
  output strobe_t    strb,
  output logic       powered,
  output logic       wakeViol
);
  localparam int WC_W = $clog2(WAKE_CLKS + 1);

  logic             csQ, sclkQ;
  logic [CNT_W-1:0] riseCnt, fallCnt;
  logic             waking;
  logic [WC_W-1:0]  wakeCnt;
  logic             csFall, csRise, sclkRise, sclkFall, riseOk, wakeStart;
  logic             newUp;

  assign csFall   = csQ & ~csN;
  assign csRise   = ~csQ & csN;
  assign sclkRise = ~sclkQ & sclk & ~csN;
  assign sclkFall = sclkQ & ~sclk & ~csN;
  assign riseOk   = sclkRise && (riseCnt < CNT_W'(FRAME_LEN));

  // new mode decides the power flag at the last rising edge
  assign newUp = !((pendingPm == PM_FULLDOWN) || (pendingPm == PM_AUTODOWN));

  always_comb begin
    strb.frameStart = csFall;
    strb.shiftEn    = riseOk && (riseCnt < CNT_W'(CTRL_W));
    strb.capture    = riseOk && (riseCnt == CNT_W'(1));
    strb.commit     = riseOk && (riseCnt == CNT_W'(FRAME_LEN - 1));
    strb.outStep    = sclkFall && (fallCnt < CNT_W'(FRAME_LEN));
    strb.outIdx     = fallCnt;
    strb.idle       = csN;
  end

  assign wakeStart = sclkFall && (fallCnt == '0) && (curPm == PM_AUTODOWN) && !powered;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ     <= 1'b1;
      sclkQ   <= 1'b1;
      riseCnt <= '0;
      fallCnt <= '0;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
      if (csFall) begin
        riseCnt <= '0;
        fallCnt <= '0;
      end else begin
        if (riseOk)       riseCnt <= riseCnt + 1'b1;
        if (strb.outStep) fallCnt <= fallCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powered <= 1'b1;
    end else if (strb.commit) begin
      powered <= newUp;
    end else if (wakeStart) begin
      powered <= 1'b1;
    end else if (csRise && (riseCnt < CNT_W'(FRAME_LEN)) && (curPm == PM_AUTODOWN)) begin
      powered <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waking  <= 1'b0;
      wakeCnt <= '0;
    end else if (wakeStart) begin
      waking  <= 1'b1;
      wakeCnt <= '0;
    end else if (strb.commit) begin
      waking  <= 1'b0;
    end else if (waking) begin
      if (wakeCnt == WC_W'(WAKE_CLKS - 1)) waking <= 1'b0;
      else                                 wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     wakeViol <= 1'b0;
    else if (csFall)               wakeViol <= 1'b0;
    else if (strb.capture && waking) wakeViol <= 1'b1;
  end
endmodule

// File: rtl/adcslv_dp.sv
module adcslv_dp
  import adcslv_pkg::*;
#(
  parameter logic DOUT_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              din,
  input  logic [DATA_W-1:0] sampleIn,
  input  strobe_t           strb,
  output logic              dout,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [1:0]        pendingPm
);
  logic [CTRL_W-1:0] shiftReg;
  logic [DATA_W-1:0] sampleReg;
  logic              nextBit;

  assign pendingPm = shiftReg[1:0];

  // leading positions select nothing and stay zero
  always_comb begin
    nextBit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (strb.outIdx == CNT_W'(FRAME_LEN - 1 - i)) nextBit = sampleReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      ctrlWord  <= '0;
      sampleReg <= '0;
      dout      <= DOUT_IDLE;
    end else begin
      if (strb.shiftEn) shiftReg  <= {shiftReg[CTRL_W-2:0], din};
      if (strb.commit)  ctrlWord  <= shiftReg;
      if (strb.capture) sampleReg <= sampleIn;
      if (strb.idle)            dout <= DOUT_IDLE;
      else if (strb.frameStart) dout <= 1'b0;
      else if (strb.outStep)    dout <= nextBit;
    end
  end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adcslv_pkg::*;
#(
  parameter int   WAKE_CLKS = 20,
  parameter logic DOUT_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              dout,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              powered,
  output logic              wakeViol
);
  strobe_t    strb;
  logic [1:0] pendingPm;

  adcslv_ctrl #(.WAKE_CLKS(WAKE_CLKS)) ctrlU (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .pendingPm(pendingPm), .curPm(ctrlWord[1:0]),
    .strb(strb), .powered(powered), .wakeViol(wakeViol)
  );

  adcslv_dp #(.DOUT_IDLE(DOUT_IDLE)) dpU (
    .clk(clk), .rstN(rstN), .din(din), .sampleIn(sampleIn),
    .strb(strb), .dout(dout), .ctrlWord(ctrlWord), .pendingPm(pendingPm)
  );
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk
  import adcslv_pkg::*;
#(
  parameter logic DOUT_IDLE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              dout,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              powered,
  input logic              wakeViol,
  input strobe_t           strb
);
  assert_idle_dout_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (dout == DOUT_IDLE));

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(ctrlWord));

  assert_full_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[1:0] == 2'b01) |-> !powered);

  assert_power_up_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powered) |-> $past(strb.commit || (strb.outStep && (strb.outIdx == '0))));

  assert_viol_at_sample_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeViol) |-> $past(strb.capture));
endmodule

bind adc_serial_emu adc_serial_emu_chk #(.DOUT_IDLE(DOUT_IDLE)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dout(dout), .ctrlWord(ctrlWord),
  .powered(powered), .wakeViol(wakeViol), .strb(strb)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
  localparam int WAKE = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        dout;
  logic [7:0]  ctrlWord;
  logic        powered;
  logic        wakeViol;

  int nChecks = 0;
  int nFails = 0;
  logic pAfterFall1, pAfterRise15, vAfterRise2;

  always #5 clk = ~clk;

  adc_serial_emu #(.WAKE_CLKS(WAKE), .DOUT_IDLE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleIn(sampleIn), .dout(dout), .ctrlWord(ctrlWord),
    .powered(powered), .wakeViol(wakeViol)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one frame: rises = rising serial clocks given, gap = extra clocks before rise 2
  task automatic runFrame(input logic [7:0] cw, input logic [11:0] smp,
                          input int rises, input int gap);
    logic [15:0] word;
    word = {4'b0000, smp};
    sampleIn = smp;
    csN = 1'b0;
    step();
    check("R4 dout at frame start", dout, 0);
    for (int k = 1; k <= rises; k++) begin
      sclk = 1'b0;
      step();
      if (k <= 16) check(k > 5 ? "R5 dout bit" : "R4 dout bit", dout, word[16-k]);
      if (k == 1) pAfterFall1 = powered;
      if (k == 2) repeat (gap) step();
      din  = (k <= 8) ? cw[8-k] : 1'b0;
      sclk = 1'b1;
      step();
      if (k == 2) begin
        vAfterRise2 = wakeViol;
        sampleIn = ~smp;
      end
      if (k == 15) pAfterRise15 = powered;
    end
    csN = 1'b1;
    step();
    check("R4 dout idle", dout, 1);
  endtask

  task automatic tReset();
    check("R1 ctrlWord", ctrlWord, 8'h00);
    check("R1 powered", powered, 1);
    check("R1 dout idle", dout, 1);
    check("R1 wakeViol", wakeViol, 0);
  endtask

  task automatic tNormal();
    runFrame(8'hA4, 12'hB5C, 16, 0);
    check("R2 ctrlWord", ctrlWord, 8'hA4);
    check("R6 powered normal", powered, 1);
    check("R9 no wake no viol", vAfterRise2, 0);
  endtask

  task automatic tAbortAndOverrun();
    runFrame(8'h3D, 12'h123, 9, 0);
    check("R3 aborted frame", ctrlWord, 8'hA4);
    runFrame(8'hA8, 12'h9E1, 20, 0);
    check("R3 extra rises ignored", ctrlWord, 8'hA8);
  endtask

  task automatic tFullDown();
    runFrame(8'h81, 12'h0F0, 16, 0);
    check("R6 full shutdown", powered, 0);
    runFrame(8'hC5, 12'h5A5, 16, 0);
    check("R7 stays down in frame", pAfterFall1, 0);
    check("R7 stays down", powered, 0);
    check("R7 ctrlWord", ctrlWord, 8'hC5);
    runFrame(8'h00, 12'h111, 5, 0);
    check("R7 ctrl retained", ctrlWord, 8'hC5);
    check("R7 down after abort", powered, 0);
  endtask

  task automatic tFullToNormal();
    runFrame(8'h10, 12'hFFF, 16, 0);
    check("R6 down before 16th rise", pAfterRise15, 0);
    check("R6 up at 16th rise", powered, 1);
  endtask

  task automatic tSpareMode();
    runFrame(8'h01, 12'h001, 16, 0);
    runFrame(8'h7F, 12'h800, 16, 0);
    check("R6 mode 11 before end", pAfterRise15, 0);
    check("R6 mode 11 as normal", powered, 1);
  endtask

  task automatic tAuto();
    runFrame(8'h02, 12'h3C3, 16, 0);
    check("R8 down after auto commit", powered, 0);
    runFrame(8'h02, 12'hC3C, 16, WAKE - 2);
    check("R8 up after first fall", pAfterFall1, 1);
    check("R9 late sample ok", vAfterRise2, 0);
    check("R8 up mid frame", pAfterRise15, 1);
    check("R8 down at 16th rise", powered, 0);
  endtask

  task automatic tViolation();
    runFrame(8'h02, 12'h6D2, 16, WAKE - 3);
    check("R9 sample at window edge", vAfterRise2, 1);
    check("R9 flag held", wakeViol, 1);
    runFrame(8'h02, 12'h2D6, 6, WAKE - 2);
    check("R9 cleared by new frame", vAfterRise2, 0);
    check("R8 up in aborted frame", pAfterFall1, 1);
    check("R8 down on early cs rise", powered, 0);
  endtask

  task automatic tFullToAuto();
    runFrame(8'h01, 12'h444, 16, 0);
    runFrame(8'h02, 12'h555, 16, WAKE - 2);
    check("R8 no wake from full", pAfterFall1, 0);
    check("R8 still down", powered, 0);
    runFrame(8'h02, 12'h666, 16, WAKE - 2);
    check("R8 wakes next frame", pAfterFall1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    tReset();
    tNormal();
    tAbortAndOverrun();
    tFullDown();
    tFullToNormal();
    tSpareMode();
    tAuto();
    tViolation();
    tFullToAuto();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule